// File: doc/BRIEF.md
# Reset Pulse and Mode Controller

This block sequences the reset of a small microcontroller whose reset pin works in both directions. The pin is watched as an input and, through an open-drain pull-down enable, also driven low by the block itself. A reset event can come from either of two sources: a high-to-low transition seen on the pin, or a request from inside the chip. When either arrives, the block pulls the pin low for a fixed number of state times. It holds the core in reset for as long as the pin stays low, and it forces any low-power mode back to normal running.

When the clock multiplier is selected, the block also keeps the internal CPU and peripheral clocks gated after a reset event. They stay gated until a settling interval has been counted. The interval is a parameter, sized from the input clock for about 2 ms in silicon and kept short in simulation. When the core is released, the block gives a one-cycle start strobe together with the fixed address of the first instruction fetch. One state time is one clock cycle of `clk`.

Top module: `rst_pulse_ctrl`

## Requirements
- R1: After a reset event is accepted, `pull_dn_en_o` is high for exactly PULSE_LEN (default 16) consecutive cycles. `core_rst_n_o` goes low in the same cycle as the pull-down.
- R2: A reset event is a falling edge of the pin level after synchronisation, or `int_rst_req_i` high at a clock edge. Events that arrive while the pull-down is active are ignored, so one event gives exactly one pulse and the block's own pull-down never retriggers it.
- R3: `core_rst_n_o` stays low for as long as the synchronised pin is low. With the pulse over and the clock multiplier off, it rises SYNC_STAGES+1 (default 3) cycles after the pin returns high. An internal request with the multiplier off therefore gives 19 cycles of reset.
- R4: With `pll_sel_i` = 01 (x2) or 11 (x4), `clk_en_o` is low for exactly SETTLE_CYC cycles (default 40) from the accepted event. The core is not released before SETTLE_CYC+1 cycles after that event.
- R5: With `pll_sel_i` = 00 (multiplier off), `clk_en_o` stays high throughout reset.
- R6: `pll_sel_i` = 10 is reserved. It raises `pll_err_o` and is handled exactly like 00.
- R7: Outside reset, `mode_wr_i` loads `mode_val_i` into `mode_o` on the next edge. The encodings are 00 run, 01 idle, 10 standby, 11 power-down. Any accepted reset event forces `mode_o` to 00, and writes made while in reset are ignored.
- R8: `fetch_go_o` is a single-cycle pulse in the first cycle `core_rst_n_o` is high after reset, and `fetch_addr_o` then reads 24'hFF2080.
- R9: While `arst_n` is low, `core_rst_n_o`=0, `pull_dn_en_o`=1, `mode_o`=00 and `fetch_go_o`=0. After `arst_n` rises with the multiplier off, the core is released after PULSE_LEN+SYNC_STAGES cycles (18).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one state time per cycle |
| arst_n | input | 1 | Asynchronous power-on reset of the block, active low |
| rst_pin_i | input | 1 | Observed level of the bidirectional reset pin |
| int_rst_req_i | input | 1 | Reset request from inside the chip |
| pll_sel_i | input | 2 | Clock multiplier select: 00 off, 01 x2, 10 reserved, 11 x4 |
| mode_wr_i | input | 1 | Strobe that loads a new operating mode |
| mode_val_i | input | 2 | Requested operating mode |
| pull_dn_en_o | output | 1 | Enables the open-drain pull-down on the reset pin |
| core_rst_n_o | output | 1 | Reset to CPU and peripherals, active low |
| clk_en_o | output | 1 | Enable for the internal CPU and peripheral clocks |
| mode_o | output | 2 | Current operating mode |
| pll_err_o | output | 1 | Reserved multiplier select present |
| fetch_go_o | output | 1 | One-cycle strobe at reset release |
| fetch_addr_o | output | 24 | Address of the first instruction fetch |

## Verification
The bench targets the pin's own pull-down echoing back through the synchroniser. A design that failed to mask that echo would show two pull-down pulses and a reset about twice as long. External holds both shorter and longer than the pulse are used, so that a design treating the pin as edge-only would release while the pin is still low, and one that ignores the pulse would release early on a glitch. All four multiplier selects are driven: wrong gating would show up as a clock-enable low count other than the settling interval, and a design that treats the reserved code as a multiplier setting would stretch the reset. Mode writes issued during reset catch a design that lets them through, where the mode would read back non-zero after release.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_IDLE = 2'b01,
        MODE_STBY = 2'b10,
        MODE_PDN  = 2'b11
    } mode_e;

    localparam logic [1:0] PLL_OFF  = 2'b00;
    localparam logic [1:0] PLL_X2   = 2'b01;
    localparam logic [1:0] PLL_RSVD = 2'b10;
    localparam logic [1:0] PLL_X4   = 2'b11;
endpackage

// File: rtl/rpc_sync.sv
module rpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;

    typedef struct packed {
        logic [N-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (N == 1) st_d.sh = d_i;
        else        st_d.sh = {st_q.sh[N-2:0], d_i};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q_o = st_q.sh[N-1];
endmodule

// File: rtl/rpc_pulse.sv
module rpc_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic start_i,
    output logic active_o
);
    localparam int CW = $clog2((LEN > 1) ? LEN : 2);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = LAST;
        end else if (st_q.active) begin
            if (st_q.cnt == '0) st_d.active = 1'b0;
            else                st_d.cnt    = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.active <= 1'b1;
            st_q.cnt    <= LAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    // R1
    pulse_no_cut_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q.active && st_q.cnt != '0) |=> st_q.active);
endmodule

// File: rtl/rpc_settle.sv
module rpc_settle #(
    parameter int CYC = 40
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    typedef struct packed {
        logic          done;
        logic [CW-1:0] cnt;
    } settle_st_t;

    settle_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.done = 1'b0;
            st_d.cnt  = '0;
        end else if (run_i && !st_q.done) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign done_o = st_q.done;

    // R4
    settle_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q.done && !clear_i) |=> st_q.done);
endmodule

// File: rtl/rst_pulse_ctrl.sv
module rst_pulse_ctrl import rpc_pkg::*; #(
    parameter int                PULSE_LEN   = 16,
    parameter int                SETTLE_CYC  = 40,
    parameter int                SYNC_STAGES = 2,
    parameter int                ADDR_W      = 24,
    parameter logic [ADDR_W-1:0] RESET_VEC   = 24'hFF2080
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              rst_pin_i,
    input  logic              int_rst_req_i,
    input  logic [1:0]        pll_sel_i,
    input  logic              mode_wr_i,
    input  logic [1:0]        mode_val_i,
    output logic              pull_dn_en_o,
    output logic              core_rst_n_o,
    output logic              clk_en_o,
    output logic [1:0]        mode_o,
    output logic              pll_err_o,
    output logic              fetch_go_o,
    output logic [ADDR_W-1:0] fetch_addr_o
);
    typedef struct packed {
        logic       prev;
        logic       rst_act;
        logic [1:0] pll;
        mode_e      mode;
        logic       fetch_go;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic pin_s;
    logic pulse_act;
    logic settled;
    logic pll_on;
    logic trig;

    rpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_i    (rst_pin_i),
        .q_o    (pin_s)
    );

    rpc_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk      (clk),
        .arst_n   (arst_n),
        .start_i  (trig),
        .active_o (pulse_act)
    );

    rpc_settle #(.CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .arst_n  (arst_n),
        .clear_i (trig),
        .run_i   (st_q.rst_act),
        .done_o  (settled)
    );

    // Reserved select is treated as multiplier off.
    assign pll_on = (st_q.pll == PLL_X2) || (st_q.pll == PLL_X4);

    // Own pull-down masks every event so the echo cannot retrigger.
    assign trig = (int_rst_req_i || (st_q.prev && !pin_s)) && !pulse_act;

    always_comb begin
        st_d          = st_q;
        st_d.prev     = pin_s;
        st_d.pll      = pll_sel_i;
        st_d.fetch_go = 1'b0;
        if (trig) begin
            st_d.rst_act = 1'b1;
            st_d.mode    = MODE_RUN;
        end else if (st_q.rst_act && !pulse_act && pin_s && (!pll_on || settled)) begin
            st_d.rst_act  = 1'b0;
            st_d.fetch_go = 1'b1;
        end else if (!st_q.rst_act && mode_wr_i) begin
            st_d.mode = mode_e'(mode_val_i);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.prev     <= 1'b0;
            st_q.rst_act  <= 1'b1;
            st_q.pll      <= PLL_OFF;
            st_q.mode     <= MODE_RUN;
            st_q.fetch_go <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_dn_en_o = pulse_act;
    assign core_rst_n_o = !st_q.rst_act;
    assign clk_en_o     = !(st_q.rst_act && pll_on && !settled);
    assign mode_o       = st_q.mode;
    assign pll_err_o    = (st_q.pll == PLL_RSVD);
    assign fetch_go_o   = st_q.fetch_go;
    assign fetch_addr_o = RESET_VEC;

    // R1
    pulse_start_chk: assert property (@(posedge clk) disable iff (!arst_n)
        trig |=> (pull_dn_en_o && !core_rst_n_o));

    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q.rst_act && !pin_s) |=> st_q.rst_act);

    // R4
    pll_gate_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(core_rst_n_o) |-> (!$past(pll_on) || $past(settled)));

    // R6
    rsvd_off_chk: assert property (@(posedge clk) disable iff (!arst_n)
        pll_err_o |-> clk_en_o);

    // R7
    mode_force_chk: assert property (@(posedge clk) disable iff (!arst_n)
        trig |=> (mode_o == MODE_RUN));

    // R8
    fetch_strobe_chk: assert property (@(posedge clk) disable iff (!arst_n)
        fetch_go_o |-> (core_rst_n_o && $past(!core_rst_n_o)));
endmodule

// File: tb/tb_rst_pulse_ctrl.sv
`timescale 1ns/1ps
module tb_rst_pulse_ctrl;
    localparam int P = 16;
    localparam int S = 40;
    localparam int SY = 2;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic ext_low = 1'b0;
    logic int_req = 1'b0;
    logic [1:0] pll_sel = 2'b00;
    logic mode_wr = 1'b0;
    logic [1:0] mode_val = 2'b00;
    logic pull_dn, core_rst_n, clk_en, pll_err, fetch_go;
    logic [1:0] mode;
    logic [23:0] fetch_addr;
    logic rst_pin;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    assign rst_pin = ~(pull_dn | ext_low);

    rst_pulse_ctrl dut (
        .clk(clk), .arst_n(arst_n), .rst_pin_i(rst_pin), .int_rst_req_i(int_req),
        .pll_sel_i(pll_sel), .mode_wr_i(mode_wr), .mode_val_i(mode_val),
        .pull_dn_en_o(pull_dn), .core_rst_n_o(core_rst_n), .clk_en_o(clk_en),
        .mode_o(mode), .pll_err_o(pll_err), .fetch_go_o(fetch_go), .fetch_addr_o(fetch_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_pll(input logic [1:0] sel);
        return (sel == 2'b01) || (sel == 2'b11);
    endfunction

    function automatic int exp_low(input bit use_ext, input int hold, input logic [1:0] sel);
        int v;
        v = P + SY + 1;
        if (use_ext && hold > v) v = hold;
        if (is_pll(sel) && (S + 1) > v) v = S + 1;
        return v;
    endfunction

    task automatic episode(input bit use_ext, input int hold, input logic [1:0] sel);
        int low_n = 0, clk_off = 0, pd_hi = 0, pd_rise = 0, early_go = 0, hold_bad = 0;
        bit seen = 0, done = 0, pd_prev = 0;
        logic fg = 1'b0;
        logic [23:0] fa = '0;
        logic [1:0] mv;
        mv = 2'($urandom_range(1, 3));
        @(negedge clk);
        pll_sel = sel;
        mode_wr = 1'b1;
        mode_val = mv;
        @(negedge clk);
        mode_wr = 1'b0;
        chk(mode == mv, "R7 mode write", int'(mode), int'(mv));
        repeat (3) @(negedge clk);
        chk(pll_err == (sel == 2'b10), "R6 pll_err", int'(pll_err), int'(sel == 2'b10));
        if (use_ext) ext_low = 1'b1; else int_req = 1'b1;
        for (int c = 1; c <= 3000 && !done; c++) begin
            @(negedge clk);
            if (!core_rst_n) begin
                low_n++;
                seen = 1;
                if (fetch_go) early_go++;
                if (!clk_en) clk_off++;
            end else if (seen) begin
                fg = fetch_go;
                fa = fetch_addr;
                done = 1;
            end
            if (use_ext && c > 3 && c <= hold && core_rst_n) hold_bad++;
            if (pull_dn) pd_hi++;
            if (pull_dn && !pd_prev) pd_rise++;
            pd_prev = pull_dn;
            if (!use_ext && c == hold) int_req = 1'b0;
            if (use_ext && c == hold) ext_low = 1'b0;
            if (c == 5) begin mode_wr = 1'b1; mode_val = 2'b11; end
            if (c == 6) mode_wr = 1'b0;
        end
        chk(done, "R3 release seen", int'(done), 1);
        chk(low_n == exp_low(use_ext, hold, sel), "R3/R4 reset length", low_n, exp_low(use_ext, hold, sel));
        chk(pd_hi == P, "R1 pull-down length", pd_hi, P);
        chk(pd_rise == 1, "R2 single pulse", pd_rise, 1);
        chk(clk_off == (is_pll(sel) ? S : 0), "R4/R5 clk_en low count", clk_off, is_pll(sel) ? S : 0);
        chk(hold_bad == 0, "R3 held while pin low", hold_bad, 0);
        chk(fg == 1'b1 && early_go == 0, "R8 fetch strobe", int'(fg), 1);
        chk(fa == 24'hFF2080, "R8 fetch address", int'(fa), 24'hFF2080);
        chk(mode == 2'b00, "R7 forced run, write in reset ignored", int'(mode), 0);
        @(negedge clk);
        chk(fetch_go == 1'b0, "R8 strobe one cycle", int'(fetch_go), 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int pl = 0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(core_rst_n == 1'b0, "R9 core reset in arst", int'(core_rst_n), 0);
        chk(pull_dn == 1'b1, "R9 pull-down in arst", int'(pull_dn), 1);
        chk(mode == 2'b00, "R9 mode in arst", int'(mode), 0);
        chk(fetch_go == 1'b0, "R9 fetch_go in arst", int'(fetch_go), 0);
        chk(clk_en == 1'b1, "R5 clk_en with pll off", int'(clk_en), 1);
        arst_n = 1'b1;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (core_rst_n) break;
            pl++;
        end
        chk(pl == P + SY, "R9 power-on release", pl, P + SY);
        repeat (4) @(negedge clk);
        // directed corner cases
        episode(1'b0, 1, 2'b00);
        episode(1'b0, 3, 2'b00);   // R2 request held into own pulse
        episode(1'b0, 1, 2'b01);
        episode(1'b0, 2, 2'b11);
        episode(1'b0, 1, 2'b10);   // R6 reserved acts as off
        episode(1'b1, 1, 2'b00);   // R3 one-cycle glitch
        episode(1'b1, 19, 2'b00);
        episode(1'b1, 60, 2'b00);  // R3 long hold
        episode(1'b1, 10, 2'b01);
        episode(1'b1, 70, 2'b11);
        // random mix
        for (int i = 0; i < 20; i++) begin
            bit e;
            int h;
            logic [1:0] s;
            e = 1'($urandom_range(0, 1));
            h = e ? int'($urandom_range(1, 70)) : int'($urandom_range(1, 5));
            s = 2'($urandom_range(0, 3));
            episode(e, h, s);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule